// File: doc/BRIEF.md
# Wired-AND Shared Bus Resolver

This block gives a chip a shared on-chip bus that many sources may drive at once, without any real tristate lines. Each source offers a data word and an enable. Every bus bit behaves like a line with a pull-up and strong low drivers. A released bit floats to its idle level. When enabled sources disagree on a bit, the result is set by a fixed rule and no damage is possible.

A parameter selects the polarity. In the default polarity the idle level is high and a disagreement resolves low. In the inverted polarity, data is inverted on the way onto the bus and again on the way off. The idle level is then low and a disagreement resolves high. A runtime override can replace the idle value with a chosen word whenever no source is enabled.

The block flags an idle bus and a driver conflict. It also keeps a registered copy of the bus and of both flags, for consumers that need timing closure.

Top module: `ebus_bus`

## Requirements
- R1: In default polarity, with no enable set and the override off, every bit of `bus_o` is 1.
- R2: In default polarity, each bus bit equals the AND over all sources of (NOT enable OR data bit), so enabled sources that disagree on a bit give 0 on that bit.
- R3: With exactly one enable set, `bus_o` equals that source's data word and `conflict_o` is 0.
- R4: In inverted polarity, each bus bit equals the OR over all sources of (enable AND data bit). The idle value is then all zeros, and a disagreement gives 1.
- R5: With `ovr_on`=1 and no enable set, `bus_o` equals `ovr_level`; while any enable is set, `ovr_on` and `ovr_level` have no effect on `bus_o`.
- R6: `idle_o` is 1 exactly when every bit of `src_en` is 0.
- R7: `conflict_o` is 1 exactly when, on some bit, one enabled source presents 1 and another enabled source presents 0.
- R8: `bus_q_o`, `idle_q_o` and `conflict_q_o` take the values of `bus_o`, `idle_o` and `conflict_o` at each rising clock edge while `rst_n` is 1.
- R9: A rising edge with `rst_n`=0 sets `bus_q_o` to the polarity's idle value (all ones in default polarity, all zeros in inverted), `idle_q_o` to 1 and `conflict_q_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered copy |
| rst_n | input | 1 | Synchronous reset, active low |
| src_data | input | N_SRC*WIDTH | Source data words; source s occupies bits s*WIDTH +: WIDTH |
| src_en | input | N_SRC | Per-source drive enable, bit s for source s |
| ovr_on | input | 1 | Enables the idle override |
| ovr_level | input | WIDTH | Word placed on the bus when idle and the override is on |
| bus_o | output | WIDTH | Resolved bus value, combinational |
| idle_o | output | 1 | No source enabled, combinational |
| conflict_o | output | 1 | Enabled sources disagree on some bit, combinational |
| bus_q_o | output | WIDTH | Registered bus value |
| idle_q_o | output | 1 | Registered idle flag |
| conflict_q_o | output | 1 | Registered conflict flag |

## Verification
On every clock the assertions check several properties. An idle bus shows either the polarity's idle word or the override word. A single driver never raises a conflict. A flagged conflict always pulls the bus away from its idle word. The registered copy tracks the combinational outputs one edge later, and reset loads the idle state. Only the bench scenarios can show the exact bitwise resolution: that result needs a reference model over every enable pattern with random data, in both polarities and with the override on and off. The same holds for the check that the override is ignored while a driver is active.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
    // Idle level of the emulated line: pulled high or (after inversion) low.
    typedef enum logic {
        POL_HIGH_IDLE = 1'b0,
        POL_LOW_IDLE  = 1'b1
    } ebus_pol_e;
endpackage

// File: rtl/ebus_resolve.sv
// Per-bit wired-AND resolution; inverted polarity flips data in and out.
module ebus_resolve #(
    parameter int N_SRC = 4,
    parameter int WIDTH = 8,
    parameter ebus_pkg::ebus_pol_e POLARITY = ebus_pkg::POL_HIGH_IDLE
) (
    input  logic [N_SRC*WIDTH-1:0] src_data,
    input  logic [N_SRC-1:0]       src_en,
    output logic [WIDTH-1:0]       wired
);
    localparam bit FLIP = (POLARITY == ebus_pkg::POL_LOW_IDLE);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [N_SRC-1:0] release_or_high;
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            logic line_val;
            if (FLIP) begin : g_inv
                assign line_val = ~src_data[s*WIDTH + b];
            end else begin : g_dir
                assign line_val = src_data[s*WIDTH + b];
            end
            assign release_or_high[s] = ~src_en[s] | line_val;
        end
        if (FLIP) begin : g_out_inv
            assign wired[b] = ~(&release_or_high);
        end else begin : g_out_dir
            assign wired[b] = &release_or_high;
        end
    end
endmodule

// File: rtl/ebus_detect.sv
// Idle and driver-conflict detection on the raw source words.
module ebus_detect #(
    parameter int N_SRC = 4,
    parameter int WIDTH = 8
) (
    input  logic [N_SRC*WIDTH-1:0] src_data,
    input  logic [N_SRC-1:0]       src_en,
    output logic                   idle,
    output logic                   conflict
);
    logic [WIDTH-1:0] seen_one;
    logic [WIDTH-1:0] seen_zero;

    always_comb begin
        seen_one  = '0;
        seen_zero = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (src_en[s]) begin
                seen_one  = seen_one  |  src_data[s*WIDTH +: WIDTH];
                seen_zero = seen_zero | ~src_data[s*WIDTH +: WIDTH];
            end
        end
        idle     = (src_en == '0);
        conflict = |(seen_one & seen_zero);
    end
endmodule

// File: rtl/ebus_bus.sv
module ebus_bus #(
    parameter int N_SRC = 4,
    parameter int WIDTH = 8,
    parameter ebus_pkg::ebus_pol_e POLARITY = ebus_pkg::POL_HIGH_IDLE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC*WIDTH-1:0] src_data,
    input  logic [N_SRC-1:0]       src_en,
    input  logic                   ovr_on,
    input  logic [WIDTH-1:0]       ovr_level,
    output logic [WIDTH-1:0]       bus_o,
    output logic                   idle_o,
    output logic                   conflict_o,
    output logic [WIDTH-1:0]       bus_q_o,
    output logic                   idle_q_o,
    output logic                   conflict_q_o
);
    localparam logic [WIDTH-1:0] IDLE_WORD =
        (POLARITY == ebus_pkg::POL_LOW_IDLE) ? '0 : '1;

    typedef struct packed {
        logic [WIDTH-1:0] bus;
        logic             idle;
        logic             conflict;
    } view_t;

    logic [WIDTH-1:0] wired;
    logic             idle_w;
    logic             conflict_w;
    view_t            view_d;
    view_t            view_q;

    ebus_resolve #(.N_SRC(N_SRC), .WIDTH(WIDTH), .POLARITY(POLARITY)) u_resolve (
        .src_data (src_data),
        .src_en   (src_en),
        .wired    (wired)
    );

    ebus_detect #(.N_SRC(N_SRC), .WIDTH(WIDTH)) u_detect (
        .src_data (src_data),
        .src_en   (src_en),
        .idle     (idle_w),
        .conflict (conflict_w)
    );

    always_comb begin
        view_d.bus      = (idle_w && ovr_on) ? ovr_level : wired;
        view_d.idle     = idle_w;
        view_d.conflict = conflict_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            view_q.bus      <= IDLE_WORD;
            view_q.idle     <= 1'b1;
            view_q.conflict <= 1'b0;
        end else begin
            view_q <= view_d;
        end
    end

    assign bus_o        = view_d.bus;
    assign idle_o       = view_d.idle;
    assign conflict_o   = view_d.conflict;
    assign bus_q_o      = view_q.bus;
    assign idle_q_o     = view_q.idle;
    assign conflict_q_o = view_q.conflict;
endmodule

// File: rtl/ebus_chk.sv
module ebus_chk #(
    parameter int N_SRC = 4,
    parameter int WIDTH = 8,
    parameter ebus_pkg::ebus_pol_e POLARITY = ebus_pkg::POL_HIGH_IDLE
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_en,
    input logic             ovr_on,
    input logic [WIDTH-1:0] ovr_level,
    input logic [WIDTH-1:0] bus_o,
    input logic             idle_o,
    input logic             conflict_o,
    input logic [WIDTH-1:0] bus_q_o,
    input logic             idle_q_o,
    input logic             conflict_q_o
);
    localparam logic [WIDTH-1:0] IDLE_WORD =
        (POLARITY == ebus_pkg::POL_LOW_IDLE) ? '0 : '1;

    // R1 / R4: released bus shows the polarity's idle word
    a_r1_idle_value: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && !ovr_on) |-> (bus_o == IDLE_WORD));

    a_r5_override: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && ovr_on) |-> (bus_o == ovr_level));

    a_r3_single_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(src_en) == 1) |-> (!conflict_o && !idle_o));

    // R2 / R7: a disagreement drags at least one bit off the idle level
    a_r7_conflict_moves_bus: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> (bus_o != IDLE_WORD));

    a_r8_reg_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (bus_q_o == $past(bus_o) && idle_q_o == $past(idle_o)
                   && conflict_q_o == $past(conflict_o)));

    a_r9_reset_state: assert property (@(posedge clk)
        !rst_n |=> (bus_q_o == IDLE_WORD && idle_q_o && !conflict_q_o));
endmodule

bind ebus_bus ebus_chk #(.N_SRC(N_SRC), .WIDTH(WIDTH), .POLARITY(POLARITY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_en       (src_en),
    .ovr_on       (ovr_on),
    .ovr_level    (ovr_level),
    .bus_o        (bus_o),
    .idle_o       (idle_o),
    .conflict_o   (conflict_o),
    .bus_q_o      (bus_q_o),
    .idle_q_o     (idle_q_o),
    .conflict_q_o (conflict_q_o)
);

// File: tb/sim_ebus_bus.sv
module sim_ebus_bus;
    localparam int N = 4;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] b0;
        logic [W-1:0] b1;
        logic         idle;
        logic         conf;
        string        tag;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*W-1:0] src_data = '0;
    logic [N-1:0]   src_en = '0;
    logic           ovr_on = 1'b0;
    logic [W-1:0]   ovr_level = '0;
    logic [W-1:0]   bus0, bus1, busq0, busq1;
    logic           idle0, idle1, conf0, conf1, idleq0, idleq1, confq0, confq1;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t sb[$];

    always #2 clk = ~clk;

    ebus_bus #(.N_SRC(N), .WIDTH(W), .POLARITY(ebus_pkg::POL_HIGH_IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_en(src_en),
        .ovr_on(ovr_on), .ovr_level(ovr_level), .bus_o(bus0), .idle_o(idle0),
        .conflict_o(conf0), .bus_q_o(busq0), .idle_q_o(idleq0), .conflict_q_o(confq0));

    ebus_bus #(.N_SRC(N), .WIDTH(W), .POLARITY(ebus_pkg::POL_LOW_IDLE)) u1 (
        .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_en(src_en),
        .ovr_on(ovr_on), .ovr_level(ovr_level), .bus_o(bus1), .idle_o(idle1),
        .conflict_o(conf1), .bus_q_o(busq1), .idle_q_o(idleq1), .conflict_q_o(confq1));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model taken from the requirements
    function automatic item_t model(input logic [N*W-1:0] d, input logic [N-1:0] en,
                                    input logic ov, input logic [W-1:0] lvl);
        item_t r;
        logic [W-1:0] hi, lo;
        r.b0 = '1; r.b1 = '0; hi = '0; lo = '0;
        for (int s = 0; s < N; s++) begin
            for (int b = 0; b < W; b++) begin
                r.b0[b] = r.b0[b] & (~en[s] | d[s*W+b]);
                r.b1[b] = r.b1[b] | (en[s] & d[s*W+b]);
                if (en[s]) begin
                    hi[b] = hi[b] | d[s*W+b];
                    lo[b] = lo[b] | ~d[s*W+b];
                end
            end
        end
        r.idle = (en == '0);
        r.conf = |(hi & lo);
        if (r.idle && ov) begin
            r.b0 = lvl;
            r.b1 = lvl;
        end
        return r;
    endfunction

    task automatic drive(input logic [N*W-1:0] d, input logic [N-1:0] en,
                         input logic ov, input logic [W-1:0] lvl, input string tag);
        item_t it;
        @(negedge clk);
        src_data = d; src_en = en; ovr_on = ov; ovr_level = lvl;
        it = model(d, en, ov, lvl);
        it.tag = tag;
        sb.push_back(it);
    endtask

    function automatic string auto_tag(input logic [N-1:0] en, input logic ov);
        if (en == '0) return ov ? "R5" : "R1";
        if ($countones(en) == 1) return "R3";
        return "R2";
    endfunction

    // Monitor: one item per rising edge, sampled 1 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t e;
                e = sb.pop_front();
                check(bus0 === e.b0, e.tag, "bus default polarity", bus0, e.b0);
                check(bus1 === e.b1, "R4", "bus inverted polarity", bus1, e.b1);
                check(idle0 === e.idle && idle1 === e.idle, "R6", "idle flag",
                      {7'd0, idle0}, {7'd0, e.idle});
                check(conf0 === e.conf && conf1 === e.conf, "R7", "conflict flag",
                      {7'd0, conf0}, {7'd0, e.conf});
                check(busq0 === e.b0 && busq1 === e.b1, "R8", "registered bus",
                      busq0, e.b0);
                check(idleq0 === e.idle && confq0 === e.conf, "R8", "registered flags",
                      {6'd0, idleq0, confq0}, {6'd0, e.idle, e.conf});
            end
        end
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state of the registered copy
        check(busq0 === 8'hFF && idleq0 === 1'b1 && confq0 === 1'b0, "R9",
              "reset default polarity", busq0, 8'hFF);
        check(busq1 === 8'h00 && idleq1 === 1'b1 && confq1 === 1'b0, "R9",
              "reset inverted polarity", busq1, 8'h00);
        rst_n = 1'b1;

        // Directed: opposite drivers on all bits, sources 0 and 1
        drive({16'h0000, 8'h0F, 8'hF0}, 4'b0011, 1'b0, 8'h00, "R2");
        // Directed: partial disagreement
        drive({8'hAA, 8'h00, 8'h00, 8'hA5}, 4'b1001, 1'b0, 8'h00, "R2");
        // Directed: single driver passes through
        drive({8'h3C, 8'h00, 8'h00, 8'h00}, 4'b1000, 1'b0, 8'h00, "R3");
        // Directed: override ignored while a driver is active
        drive({8'h00, 8'h5A, 8'h00, 8'h00}, 4'b0100, 1'b1, 8'hC3, "R5");
        // Directed: override applied when idle
        drive('0, 4'b0000, 1'b1, 8'h96, "R5");
        drive('0, 4'b0000, 1'b0, 8'h96, "R1");
        // Directed: agreeing drivers give no conflict
        drive({8'h77, 8'h77, 8'h77, 8'h77}, 4'b1111, 1'b0, 8'h00, "R2");

        // Every enable pattern, random data, override off and on
        for (int rnd = 0; rnd < 4; rnd++) begin
            for (int ov = 0; ov < 2; ov++) begin
                for (int en = 0; en < (1 << N); en++) begin
                    logic [N*W-1:0] d;
                    d = {$urandom, $urandom};
                    if (rnd == 0) d = {N{8'hC5}} ^ {N*W{en[0]}};
                    drive(d, en[N-1:0], ov[0], 8'($urandom),
                          auto_tag(en[N-1:0], ov[0]));
                end
            end
        end

        // Reset mid-run: registered copy returns to idle (R9)
        @(negedge clk);
        rst_n = 1'b0;
        src_en = 4'b0011;
        src_data = {16'h0000, 8'h0F, 8'hF0};
        @(negedge clk);
        check(busq0 === 8'hFF && idleq0 === 1'b1 && confq0 === 1'b0, "R9",
              "mid-run reset", busq0, 8'hFF);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule